// File: doc/BRIEF.md
# Parity-Interleaved Dual-Read Memory

This block is an on-chip element array that returns two neighbouring elements, A[i] and A[i+1], in a single cycle. Storage is split into two banks by the parity of the element index, so any adjacent pair always touches each bank exactly once. A plain single-port array would need two cycles per pair; here a new pair may be requested on every clock.

A request carries a base index and a valid strobe. The decoder works out, from the parity of the base index, which bank holds the lower element and what local address each bank must read. One cycle later, a steering stage puts the lower element on lane 0 and the upper element on lane 1, whatever the parity was. If the upper index runs past the end of the array, the result is flagged and the missing lane reads as zero. A separate write port loads the array one element per cycle, and sends each element to its bank by index parity.

Top module: `pair_ilv_mem`

## Requirements
- R1: During and right after reset, with no request issued, rd_vld_o and rd_err_o are 0.
- R2: For an even base index i below DEPTH-1, one cycle after the request rd_data0_o equals A[i] and rd_data1_o equals A[i+1].
- R3: For an odd base index i below DEPTH-1, the lanes keep index order: rd_data0_o equals A[i] and rd_data1_o equals A[i+1]. The upper element comes from the even bank at local address (i+1)/2.
- R4: rd_vld_o equals rd_vld_i delayed by exactly one clock cycle.
- R5: Requests issued on consecutive cycles each return their own correct pair on consecutive cycles, with no stall.
- R6: A valid request with i+1 >= DEPTH raises rd_err_o together with rd_vld_o and returns zero on rd_data1_o. rd_data0_o still carries A[i] when i = DEPTH-1, and reads zero when i >= DEPTH.
- R7: A write of wr_data_i at wr_idx_i < DEPTH updates element wr_idx_i only, stored in bank wr_idx_i[0] at local address wr_idx_i/2. Later reads return the new value.
- R8: A write with wr_idx_i >= DEPTH is ignored: no element changes, including the element whose local address the truncated index would alias.
- R9: A read and a write of the same element in the same cycle return the old value for that read. The next read returns the new value.
- R10: rd_err_o is never 1 while rd_vld_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | IDX_W | Element index to write |
| wr_data_i | input | DATA_W | Data to write |
| rd_vld_i | input | 1 | Pair read request |
| rd_idx_i | input | IDX_W | Base index i of the pair |
| rd_vld_o | output | 1 | Pair result valid, one cycle after the request |
| rd_err_o | output | 1 | Upper index beyond the array |
| rd_data0_o | output | DATA_W | Element A[i] |
| rd_data1_o | output | DATA_W | Element A[i+1] |

## Verification
A load write and a pair read can land in the same cycle on the same bank, and even on the same element. The bench provokes this by writing the upper element of a pair at the very edge where that pair's read is sampled. The result must carry the old value, and a repeat read of the same pair on the next cycle must carry the new one. Both values are predicted from the bench's own copy of the array.

// File: rtl/pim_pkg.sv
package pim_pkg;

   // Per-request steering flags, registered alongside the bank reads.
   typedef struct packed {
      logic swap;       // base index odd: lower element sits in the odd bank
      logic lane0_oob;  // base index beyond the array
      logic lane1_oob;  // upper index beyond the array
   } pim_flags_t;

   function automatic int unsigned pim_bank_aw(input int unsigned depth);
      return (depth / 2 > 1) ? $clog2(depth / 2) : 1;
   endfunction

endpackage

// File: rtl/pim_decode.sv
module pim_decode
   import pim_pkg::*;
#(
   parameter int unsigned DEPTH   = 64,
   parameter int unsigned IDX_W   = 7,
   parameter int unsigned BANK_AW = 5
) (
   input  logic [IDX_W-1:0]   idx_i,
   output logic [BANK_AW-1:0] even_addr_o,
   output logic [BANK_AW-1:0] odd_addr_o,
   output pim_flags_t         flags_o
);

   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

   logic [IDX_W:0] idx_ext;
   logic [IDX_W:0] idx_nxt;

   always_comb begin
      idx_ext = {1'b0, idx_i};
      idx_nxt = idx_ext + 1'b1;
      // odd bank always reads floor(i/2); even bank reads ceil(i/2)
      odd_addr_o  = idx_ext[BANK_AW:1];
      even_addr_o = idx_i[0] ? idx_nxt[BANK_AW:1] : idx_ext[BANK_AW:1];
      flags_o.swap      = idx_i[0];
      flags_o.lane0_oob = (idx_ext >= LIMIT);
      flags_o.lane1_oob = (idx_nxt >= LIMIT);
   end

endmodule

// File: rtl/pim_bank.sv
module pim_bank #(
   parameter int unsigned DATA_W  = 16,
   parameter int unsigned BANK_D  = 32,
   parameter int unsigned BANK_AW = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [BANK_AW-1:0] wa_i,
   input  logic [DATA_W-1:0]  wd_i,
   input  logic               re_i,
   input  logic [BANK_AW-1:0] ra_i,
   output logic [DATA_W-1:0]  q_o
);

   logic [DATA_W-1:0] mem [BANK_D];
   logic [DATA_W-1:0] rd_word;

   // Guard on addresses past the bank end only when the depth leaves a gap.
   generate
      if ((2 ** BANK_AW) == BANK_D) begin : g_full
         always_comb rd_word = mem[ra_i];
      end else begin : g_partial
         always_comb begin
            rd_word = '0;
            if (32'(ra_i) < BANK_D) rd_word = mem[ra_i];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i && (32'(wa_i) < BANK_D)) mem[wa_i] <= wd_i;
   end

   // Read returns the content from before a same-edge write.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (re_i) q_o <= rd_word;
   end

endmodule

// File: rtl/pim_steer.sv
module pim_steer
   import pim_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vld_i,
   input  pim_flags_t        flags_i,
   input  logic [DATA_W-1:0] q_even_i,
   input  logic [DATA_W-1:0] q_odd_i,
   output logic              vld_o,
   output logic              err_o,
   output logic [DATA_W-1:0] lane0_o,
   output logic [DATA_W-1:0] lane1_o
);

   pim_flags_t flags_q;
   logic       vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         flags_q <= '0;
      end else begin
         vld_q <= vld_i;
         if (vld_i) flags_q <= flags_i;
      end
   end

   always_comb begin
      vld_o   = vld_q;
      err_o   = vld_q & flags_q.lane1_oob;
      lane0_o = flags_q.swap ? q_odd_i : q_even_i;
      lane1_o = flags_q.swap ? q_even_i : q_odd_i;
      if (flags_q.lane0_oob) lane0_o = '0;
      if (flags_q.lane1_oob) lane1_o = '0;
   end

endmodule

// File: rtl/pair_ilv_mem.sv
module pair_ilv_mem
   import pim_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_vld_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic              rd_vld_o,
   output logic              rd_err_o,
   output logic [DATA_W-1:0] rd_data0_o,
   output logic [DATA_W-1:0] rd_data1_o
);

   localparam int unsigned BANK_D  = DEPTH / 2;
   localparam int unsigned BANK_AW = pim_bank_aw(DEPTH);
   localparam int unsigned NBANK   = 2;
   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

   generate
      if ((DEPTH % 2) != 0 || DEPTH < 4) begin : g_bad_depth
         $error("pair_ilv_mem: DEPTH must be even and at least 4");
      end
      if (IDX_W < BANK_AW + 1 || (2 ** IDX_W) < DEPTH) begin : g_bad_idx
         $error("pair_ilv_mem: IDX_W too narrow for DEPTH");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("pair_ilv_mem: DATA_W must be positive");
      end
   endgenerate

   logic [BANK_AW-1:0] rd_addr [NBANK];
   logic [DATA_W-1:0]  bank_q  [NBANK];
   pim_flags_t         rd_flags;
   logic               wr_ok;
   logic [BANK_AW-1:0] wr_local;
   logic [IDX_W:0]     wr_ext;

   pim_decode #(
      .DEPTH  (DEPTH),
      .IDX_W  (IDX_W),
      .BANK_AW(BANK_AW)
   ) u_decode (
      .idx_i      (rd_idx_i),
      .even_addr_o(rd_addr[0]),
      .odd_addr_o (rd_addr[1]),
      .flags_o    (rd_flags)
   );

   always_comb begin
      wr_ext   = {1'b0, wr_idx_i};
      wr_ok    = wr_en_i && (wr_ext < LIMIT);
      wr_local = wr_ext[BANK_AW:1];
   end

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         pim_bank #(
            .DATA_W (DATA_W),
            .BANK_D (BANK_D),
            .BANK_AW(BANK_AW)
         ) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .we_i (wr_ok && (wr_idx_i[0] == 1'(b))),
            .wa_i (wr_local),
            .wd_i (wr_data_i),
            .re_i (rd_vld_i),
            .ra_i (rd_addr[b]),
            .q_o  (bank_q[b])
         );
      end
   endgenerate

   pim_steer #(
      .DATA_W(DATA_W)
   ) u_steer (
      .clk     (clk),
      .rst_n   (rst_n),
      .vld_i   (rd_vld_i),
      .flags_i (rd_flags),
      .q_even_i(bank_q[0]),
      .q_odd_i (bank_q[1]),
      .vld_o   (rd_vld_o),
      .err_o   (rd_err_o),
      .lane0_o (rd_data0_o),
      .lane1_o (rd_data1_o)
   );

endmodule

// File: rtl/pim_checker.sv
module pim_checker #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned IDX_W  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_vld_i,
   input logic [IDX_W-1:0]  rd_idx_i,
   input logic              rd_vld_o,
   input logic              rd_err_o,
   input logic [DATA_W-1:0] rd_data1_o
);

   localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);

   logic hi_bad;
   always_comb hi_bad = ({1'b0, rd_idx_i} + 1'b1) >= LIMIT;

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld_i |=> rd_vld_o); // R4
   AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_vld_i |=> !rd_vld_o); // R4
   AST_ERR_ON_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld_i && hi_bad) |=> rd_err_o); // R6
   AST_NO_ERR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_vld_i && !hi_bad) |=> !rd_err_o); // R6
   AST_LANE1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err_o |-> (rd_data1_o == '0)); // R6
   AST_ERR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err_o |-> rd_vld_o); // R10

endmodule

bind pair_ilv_mem pim_checker #(
   .DATA_W(DATA_W),
   .DEPTH (DEPTH),
   .IDX_W (IDX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_vld_i  (rd_vld_i),
   .rd_idx_i  (rd_idx_i),
   .rd_vld_o  (rd_vld_o),
   .rd_err_o  (rd_err_o),
   .rd_data1_o(rd_data1_o)
);

// File: tb/pair_ilv_mem_tb_top.sv
module pair_ilv_mem_tb_top;

   localparam int DATA_W = 16;
   localparam int DEPTH  = 64;
   localparam int IDX_W  = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en_i = 1'b0;
   logic [IDX_W-1:0]  wr_idx_i = '0;
   logic [DATA_W-1:0] wr_data_i = '0;
   logic              rd_vld_i = 1'b0;
   logic [IDX_W-1:0]  rd_idx_i = '0;
   logic              rd_vld_o;
   logic              rd_err_o;
   logic [DATA_W-1:0] rd_data0_o;
   logic [DATA_W-1:0] rd_data1_o;

   logic [DATA_W-1:0] model [DEPTH];
   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   pair_ilv_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
      .rd_vld_i(rd_vld_i), .rd_idx_i(rd_idx_i),
      .rd_vld_o(rd_vld_o), .rd_err_o(rd_err_o),
      .rd_data0_o(rd_data0_o), .rd_data1_o(rd_data1_o)
   );

   function automatic logic [DATA_W-1:0] pat(input int k, input int s);
      return DATA_W'(k * 97 + s * 13 + 16'h1234);
   endfunction

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic write_elem(input int k, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en_i = 1'b1; wr_idx_i = IDX_W'(k); wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
      if (k < DEPTH) model[k] = d;
   endtask

   // Issue one request, sample its result one cycle later.
   task automatic read_pair(input string req, input int k);
      @(negedge clk);
      rd_vld_i = 1'b1; rd_idx_i = IDX_W'(k);
      @(negedge clk);
      rd_vld_i = 1'b0;
      chk({req, " valid"}, 32'(rd_vld_o), 32'd1);
      chk({req, " lane0"}, 32'(rd_data0_o), (k < DEPTH) ? 32'(model[k]) : 32'd0);
      chk({req, " lane1"}, 32'(rd_data1_o), (k + 1 < DEPTH) ? 32'(model[k+1]) : 32'd0);
      chk({req, " err"}, 32'(rd_err_o), (k + 1 >= DEPTH) ? 32'd1 : 32'd0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R1 valid in reset", 32'(rd_vld_o), 32'd0);
      chk("R1 err in reset", 32'(rd_err_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 valid after reset", 32'(rd_vld_o), 32'd0);
      chk("R1 err after reset", 32'(rd_err_o), 32'd0);
   endtask

   task automatic t_load;
      for (int k = 0; k < DEPTH; k++) write_elem(k, pat(k, 1));
   endtask

   task automatic t_even;
      read_pair("R2 even 0", 0);
      read_pair("R2 even 20", 20);
      read_pair("R2 even 62", 62);
   endtask

   task automatic t_odd;
      read_pair("R3 odd 1", 1);
      read_pair("R3 odd 31", 31);
      read_pair("R3 odd 45", 45);
   endtask

   task automatic t_stream;
      int prev = -1;
      for (int k = 3; k < 14; k++) begin
         @(negedge clk);
         if (prev >= 0) begin
            chk("R5 stream valid", 32'(rd_vld_o), 32'd1);
            chk("R5 stream lane0", 32'(rd_data0_o), 32'(model[prev]));
            chk("R5 stream lane1", 32'(rd_data1_o), 32'(model[prev+1]));
         end
         rd_vld_i = 1'b1; rd_idx_i = IDX_W'(k); prev = k;
      end
      @(negedge clk);
      rd_vld_i = 1'b0;
      chk("R5 stream last lane0", 32'(rd_data0_o), 32'(model[prev]));
      chk("R5 stream last lane1", 32'(rd_data1_o), 32'(model[prev+1]));
      @(negedge clk);
      chk("R4 valid drops", 32'(rd_vld_o), 32'd0);
      chk("R10 err idle", 32'(rd_err_o), 32'd0);
   endtask

   task automatic t_range;
      read_pair("R6 last element", DEPTH - 1);
      read_pair("R6 beyond array", DEPTH + 36);
      read_pair("R6 edge in range", DEPTH - 2);
   endtask

   task automatic t_writes;
      write_elem(6, pat(6, 2));
      write_elem(9, pat(9, 2));
      read_pair("R7 even write visible", 6);
      read_pair("R7 odd write visible", 8);
      // index DEPTH+5 aliases odd local address 2 (element 5) if truncated
      write_elem(DEPTH + 5, 16'hDEAD);
      read_pair("R8 ignored write", 4);
      read_pair("R8 ignored write odd", 5);
   endtask

   task automatic t_collide;
      logic [DATA_W-1:0] nv;
      nv = 16'hBEEF;
      @(negedge clk);
      rd_vld_i = 1'b1; rd_idx_i = IDX_W'(10);
      wr_en_i  = 1'b1; wr_idx_i = IDX_W'(11); wr_data_i = nv;
      @(negedge clk);
      wr_en_i = 1'b0;
      chk("R9 same-cycle lane1 old", 32'(rd_data1_o), 32'(model[11]));
      chk("R9 same-cycle lane0", 32'(rd_data0_o), 32'(model[10]));
      model[11] = nv;
      rd_idx_i = IDX_W'(10);
      @(negedge clk);
      rd_vld_i = 1'b0;
      chk("R9 next read new", 32'(rd_data1_o), 32'(nv));
   endtask

   initial begin
      t_reset();
      t_load();
      t_even();
      t_odd();
      t_stream();
      t_range();
      t_writes();
      t_collide();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got hung expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule